// File: doc/BRIEF.md
# Halfword Page Table Walker

This block resolves a translation miss for the simpler of two paging styles. It takes a virtual address, a table selector (executive or user), a read/write flag and a probe flag. From these it works out where the page entry lives in physical memory. Each memory word there holds two 18-bit entries. The block reads that word through a single request/response port and keeps the half that belongs to the requested page. It then checks the accessible and writable bits. The result is either an expanded entry ready to load into a translation table, or a page-fail pulse with a composed status word.

Executive entries are not in one contiguous table. Low executive pages and high executive pages hang off the executive base. A small window of executive pages in the middle is kept inside the user process table. The two base page numbers arrive as inputs and are sampled when a request is accepted. In probe mode the block never fails: an inaccessible page completes with a zero entry and a richer status word. Delivering the trap and providing the memory are left to the surrounding logic.

Top module: `hw_pt_walker`

## Requirements
- R1: For a user-table walk, the entry word address is user_base*512 + USER_MAP_OFS + (vpn>>1), where vpn = vaddr[17:9].
- R2: For an executive walk with vpn below octal 340, the entry word address is exec_base*512 + EXEC_LO_OFS + (vpn>>1).
- R3: For an executive walk with vpn from octal 340 to 377, the entry word address is user_base*512 + EXEC_MID_OFS + ((vpn-0o340)>>1).
- R4: For an executive walk with vpn of octal 400 or more, the entry word address is exec_base*512 + EXEC_HI_OFS + ((vpn-0o400)>>1).
- R5: An odd vpn selects data bits [17:0] of the fetched word, and an even vpn selects bits [35:18]. Within the selected half, bit 17 means accessible, bit 16 writable, bit 15 software and bit 14 cacheable, and bits [10:0] hold the physical page number. On success xpte_base equals that page number times 512.
- R6: Access is granted when the accessible bit is set and the reference is a read or the writable bit is set. A grant pulses walk_done with xpte_valid=1 and xpte_modify equal to the writable bit. A non-probe refusal pulses walk_fail with all xpte outputs zero.
- R7: For a walk that reads memory, status_word has bit 33 (virtual reference) set, bit 35 equal to the user-table flag, bit 32 equal to the write flag, and bits [17:0] equal to vaddr. When the accessible bit is set, bit 31 is also set and bit 29 copies the software bit. All other bits are zero.
- R8: In probe mode, status_word additionally carries writable in bit 30, software in bit 29 and cacheable in bit 28. A refused probe pulses walk_done, not walk_fail, with xpte_valid=0.
- R9: If the entry word address is MEM_WORDS or more, no memory read is issued. The status word is then bit 34 (hard error) | bit 27 (physical missing memory) | bit 35 (user flag) | the entry address in bits [19:0]. The walk fails, or in probe mode completes with a zero entry.
- R10: Each walk issues at most one single-cycle memory request. It ends with exactly one single-cycle pulse of walk_done or walk_fail, never both. req_ready is low from acceptance until that pulse.
- R11: After reset, req_ready is 1 and walk_done, walk_fail, mem_req_valid and xpte_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only while req_ready) |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 18 | Faulting virtual address |
| req_user | input | 1 | 1 selects the user table, 0 the executive table |
| req_write | input | 1 | Write reference |
| req_probe | input | 1 | Probe mode: report instead of failing |
| exec_base | input | PPN_W | Executive process table page number |
| user_base | input | PPN_W | User process table page number |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | PPN_W+9 | Entry word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 36 | Entry word (two entries) |
| walk_done | output | 1 | Walk completed pulse |
| walk_fail | output | 1 | Page fail pulse |
| xpte_valid | output | 1 | Expanded entry valid |
| xpte_modify | output | 1 | Expanded entry writable |
| xpte_base | output | PPN_W+9 | Physical page word address |
| status_word | output | 36 | Composed fault/probe status |

## Verification
A wrong region decode or a wrong base choice shows up directly on mem_req_addr, one cycle after a request is accepted. Walks that cross the octal 340 and 400 vpn boundaries, in both tables, expose this at once. A corrupted halfword select or access decision shows on xpte_base, xpte_modify and the done/fail pulse two cycles after the read data returns. Status bit errors appear in the same cycle. A stuck state machine shows as req_ready staying low or a missing completion pulse within a few cycles. Address-limit walks placed one word either side of MEM_WORDS show whether a read was issued when it should not have been.

// File: rtl/hwpt_pkg.sv
package hwpt_pkg;
    localparam int WORD_W = 36;
    localparam int HALF_W = 18;
    localparam int VA_W   = 18;
    localparam int VPN_W  = 9;
    localparam int OFF_W  = 9;

    // entry flag positions inside an 18-bit half
    localparam int ENT_A = 17;
    localparam int ENT_W = 16;
    localparam int ENT_S = 15;
    localparam int ENT_C = 14;

    // status word positions
    localparam int SW_USER  = 35;
    localparam int SW_HARD  = 34;
    localparam int SW_VIRT  = 33;
    localparam int SW_WRITE = 32;
    localparam int SW_ACC   = 31;
    localparam int SW_WR    = 30;
    localparam int SW_SOFT  = 29;
    localparam int SW_CACHE = 28;
    localparam int SW_PNXM  = 27;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CHECK = 2'd2
    } walk_state_e;
endpackage

// File: rtl/hwpt_addr_gen.sv
module hwpt_addr_gen
    import hwpt_pkg::*;
#(
    parameter int PPN_W        = 11,
    parameter int USER_MAP_OFS = 256,
    parameter int EXEC_LO_OFS  = 384,
    parameter int EXEC_MID_OFS = 64,
    parameter int EXEC_HI_OFS  = 128,
    parameter int MEM_WORDS    = 393088,
    localparam int PA_W        = PPN_W + OFF_W
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic             use_user,
    input  logic [PPN_W-1:0] exec_base,
    input  logic [PPN_W-1:0] user_base,
    output logic [PA_W-1:0]  entry_addr,
    output logic             entry_nxm
);
    localparam int SUM_W = PA_W + 1;
    localparam logic [VPN_W-1:0] MID_FIRST = VPN_W'(9'o340);
    localparam logic [VPN_W-1:0] HI_FIRST  = VPN_W'(9'o400);

    logic [PPN_W-1:0] base_sel;
    logic [SUM_W-1:0] ofs_sel;
    logic [VPN_W-1:0] rel_vpn;
    logic [SUM_W-1:0] sum;

    always_comb begin
        if (use_user) begin
            base_sel = user_base;
            ofs_sel  = SUM_W'(USER_MAP_OFS);
            rel_vpn  = vpn;
        end else if (vpn < MID_FIRST) begin
            base_sel = exec_base;
            ofs_sel  = SUM_W'(EXEC_LO_OFS);
            rel_vpn  = vpn;
        end else if (vpn < HI_FIRST) begin
            base_sel = user_base;
            ofs_sel  = SUM_W'(EXEC_MID_OFS);
            rel_vpn  = vpn - MID_FIRST;
        end else begin
            base_sel = exec_base;
            ofs_sel  = SUM_W'(EXEC_HI_OFS);
            rel_vpn  = vpn - HI_FIRST;
        end
        sum = {1'b0, base_sel, {OFF_W{1'b0}}} + ofs_sel + SUM_W'(rel_vpn >> 1);
    end

    assign entry_addr = sum[PA_W-1:0];
    assign entry_nxm  = (sum >= SUM_W'(MEM_WORDS));

    // R3: the middle window never reads from the executive base
    always_comb begin
        if (!use_user && vpn >= MID_FIRST && vpn < HI_FIRST)
            a_r3_mid_uses_user: assert (base_sel == user_base);
    end
endmodule

// File: rtl/hwpt_entry_eval.sv
module hwpt_entry_eval
    import hwpt_pkg::*;
#(
    parameter int PPN_W = 11,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              odd_page,
    input  logic              is_write,
    input  logic              is_probe,
    input  logic              is_user,
    input  logic [VA_W-1:0]   vaddr,
    output logic              grant,
    output logic              x_modify,
    output logic [PA_W-1:0]   x_base,
    output logic [WORD_W-1:0] status
);
    logic [HALF_W-1:0] half;

    assign half     = odd_page ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
    assign grant    = half[ENT_A] && (!is_write || half[ENT_W]);
    assign x_modify = half[ENT_W];
    assign x_base   = {half[PPN_W-1:0], {OFF_W{1'b0}}};

    generate
        if (PPN_W < ENT_C) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^half[ENT_C-1:PPN_W];
        end
    endgenerate

    always_comb begin
        status = '0;
        status[SW_VIRT]  = 1'b1;
        status[SW_USER]  = is_user;
        status[SW_WRITE] = is_write;
        if (half[ENT_A]) begin
            status[SW_ACC]  = 1'b1;
            status[SW_SOFT] = half[ENT_S];
        end
        if (is_probe) begin
            status[SW_WR]    = half[ENT_W];
            status[SW_SOFT]  = status[SW_SOFT] | half[ENT_S];
            status[SW_CACHE] = half[ENT_C];
        end
        status[VA_W-1:0] = vaddr;
    end
endmodule

// File: rtl/hw_pt_walker.sv
module hw_pt_walker
    import hwpt_pkg::*;
#(
    parameter int PPN_W        = 11,
    parameter int USER_MAP_OFS = 256,
    parameter int EXEC_LO_OFS  = 384,
    parameter int EXEC_MID_OFS = 64,
    parameter int EXEC_HI_OFS  = 128,
    parameter int MEM_WORDS    = 393088,
    localparam int PA_W        = PPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_user,
    input  logic              req_write,
    input  logic              req_probe,
    input  logic [PPN_W-1:0]  exec_base,
    input  logic [PPN_W-1:0]  user_base,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              walk_done,
    output logic              walk_fail,
    output logic              xpte_valid,
    output logic              xpte_modify,
    output logic [PA_W-1:0]   xpte_base,
    output logic [WORD_W-1:0] status_word
);
    typedef struct packed {
        walk_state_e       state;
        logic [VA_W-1:0]   vaddr;
        logic              user;
        logic              write;
        logic              probe;
        logic [PA_W-1:0]   addr;
        logic              nxm;
        logic [WORD_W-1:0] word;
        logic              mem_req;
        logic              done;
        logic              fail;
        logic              xv;
        logic              xm;
        logic [PA_W-1:0]   xbase;
        logic [WORD_W-1:0] status;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [PA_W-1:0]   gen_addr;
    logic              gen_nxm;
    logic              ev_grant;
    logic              ev_modify;
    logic [PA_W-1:0]   ev_base;
    logic [WORD_W-1:0] ev_status;

    hwpt_addr_gen #(
        .PPN_W        (PPN_W),
        .USER_MAP_OFS (USER_MAP_OFS),
        .EXEC_LO_OFS  (EXEC_LO_OFS),
        .EXEC_MID_OFS (EXEC_MID_OFS),
        .EXEC_HI_OFS  (EXEC_HI_OFS),
        .MEM_WORDS    (MEM_WORDS)
    ) i_addr_gen (
        .vpn        (req_vaddr[VA_W-1:OFF_W]),
        .use_user   (req_user),
        .exec_base  (exec_base),
        .user_base  (user_base),
        .entry_addr (gen_addr),
        .entry_nxm  (gen_nxm)
    );

    hwpt_entry_eval #(
        .PPN_W (PPN_W)
    ) i_entry_eval (
        .word     (walk_q.word),
        .odd_page (walk_q.vaddr[OFF_W]),
        .is_write (walk_q.write),
        .is_probe (walk_q.probe),
        .is_user  (walk_q.user),
        .vaddr    (walk_q.vaddr),
        .grant    (ev_grant),
        .x_modify (ev_modify),
        .x_base   (ev_base),
        .status   (ev_status)
    );

    always_comb begin
        walk_d         = walk_q;
        walk_d.mem_req = 1'b0;
        walk_d.done    = 1'b0;
        walk_d.fail    = 1'b0;
        walk_d.xv      = 1'b0;
        walk_d.xm      = 1'b0;
        walk_d.xbase   = '0;
        walk_d.status  = '0;
        case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.vaddr = req_vaddr;
                    walk_d.user  = req_user;
                    walk_d.write = req_write;
                    walk_d.probe = req_probe;
                    walk_d.addr  = gen_addr;
                    walk_d.nxm   = gen_nxm;
                    if (gen_nxm) begin
                        walk_d.state = ST_CHECK;
                    end else begin
                        walk_d.mem_req = 1'b1;
                        walk_d.state   = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.word  = mem_rsp_data;
                    walk_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                walk_d.state = ST_IDLE;
                if (walk_q.nxm) begin
                    walk_d.status[SW_HARD]    = 1'b1;
                    walk_d.status[SW_PNXM]    = 1'b1;
                    walk_d.status[SW_USER]    = walk_q.user;
                    walk_d.status[PA_W-1:0]   = walk_q.addr;
                    walk_d.done = walk_q.probe;
                    walk_d.fail = !walk_q.probe;
                end else if (ev_grant) begin
                    walk_d.status = ev_status;
                    walk_d.done   = 1'b1;
                    walk_d.xv     = 1'b1;
                    walk_d.xm     = ev_modify;
                    walk_d.xbase  = ev_base;
                end else begin
                    walk_d.status = ev_status;
                    walk_d.done   = walk_q.probe;
                    walk_d.fail   = !walk_q.probe;
                end
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign req_ready     = (walk_q.state == ST_IDLE);
    assign mem_req_valid = walk_q.mem_req;
    assign mem_req_addr  = walk_q.addr;
    assign walk_done     = walk_q.done;
    assign walk_fail     = walk_q.fail;
    assign xpte_valid    = walk_q.xv;
    assign xpte_modify   = walk_q.xm;
    assign xpte_base     = walk_q.xbase;
    assign status_word   = walk_q.status;

    a_r10_done_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done && walk_fail));
    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done || walk_fail) |=> !(walk_done || walk_fail));
    a_r10_busy_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    a_r6_fail_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fail |-> !xpte_valid);
    a_r6_entry_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        xpte_valid |-> walk_done);
    a_r6_modify_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        xpte_modify |-> xpte_valid);
    a_r9_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (int'(mem_req_addr) < MEM_WORDS));
    a_r9_nxm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && gen_nxm) |=> !mem_req_valid);
    a_r8_probe_never_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.state == ST_CHECK && walk_q.probe) |=> !walk_fail);
endmodule

// File: tb/test_hw_pt_walker.sv
`timescale 1ns/1ps
module test_hw_pt_walker;
    localparam int PPN_W = 11;
    localparam int PA_W  = PPN_W + 9;
    localparam int U_OFS = 256;
    localparam int LO_OFS = 384;
    localparam int MID_OFS = 64;
    localparam int HI_OFS = 128;
    localparam int MEMW = 393088;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [17:0] req_vaddr = '0;
    logic req_user = 1'b0, req_write = 1'b0, req_probe = 1'b0;
    logic [PPN_W-1:0] exec_base = '0, user_base = '0;
    logic mem_req_valid;
    logic [PA_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [35:0] mem_rsp_data = '0;
    logic walk_done, walk_fail, xpte_valid, xpte_modify;
    logic [PA_W-1:0] xpte_base;
    logic [35:0] status_word;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    hw_pt_walker #(
        .PPN_W(PPN_W), .USER_MAP_OFS(U_OFS), .EXEC_LO_OFS(LO_OFS),
        .EXEC_MID_OFS(MID_OFS), .EXEC_HI_OFS(HI_OFS), .MEM_WORDS(MEMW)
    ) i_hw_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_user(req_user), .req_write(req_write),
        .req_probe(req_probe), .exec_base(exec_base), .user_base(user_base),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .walk_done(walk_done), .walk_fail(walk_fail), .xpte_valid(xpte_valid),
        .xpte_modify(xpte_modify), .xpte_base(xpte_base), .status_word(status_word)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic int unsigned f_addr(input logic [17:0] va, input bit usr,
                                           input int unsigned eb, input int unsigned ub);
        int unsigned v = int'(va[17:9]);
        if (usr) return ub * 512 + U_OFS + v / 2;
        if (v < 'o340) return eb * 512 + LO_OFS + v / 2;
        if (v < 'o400) return ub * 512 + MID_OFS + (v - 'o340) / 2;
        return eb * 512 + HI_OFS + (v - 'o400) / 2;
    endfunction

    function automatic string f_region(input logic [17:0] va, input bit usr);
        int unsigned v = int'(va[17:9]);
        if (usr) return "R1";
        if (v < 'o340) return "R2";
        if (v < 'o400) return "R3";
        return "R4";
    endfunction

    task automatic run_walk(input logic [17:0] va, input bit usr, input bit wr,
                            input bit prb, input int unsigned eb, input int unsigned ub,
                            input logic [35:0] wd, input int dly);
        int unsigned ea;
        bit enxm, grant, e_done, e_fail, e_xv, e_xm;
        logic [17:0] hw;
        logic [35:0] e_st;
        logic [63:0] e_xb;
        int nreq = 0;
        bit pend = 0, seen = 0;
        int cnt = 0;
        logic [PA_W-1:0] gaddr = '0;
        logic g_done = 0, g_fail = 0, g_xv = 0, g_xm = 0;
        logic [PA_W-1:0] g_xb = '0;
        logic [35:0] g_st = '0;
        string rtag;

        ea   = f_addr(va, usr, eb, ub);
        enxm = (ea >= MEMW);
        rtag = f_region(va, usr);
        hw   = va[9] ? wd[17:0] : wd[35:18];
        e_st = '0; e_xv = 0; e_xm = 0; e_xb = 0;
        if (enxm) begin
            e_st = (36'(usr) << 35) | (36'd1 << 34) | (36'd1 << 27) | 36'(ea);
            e_done = prb; e_fail = !prb;
        end else begin
            grant = hw[17] && (!wr || hw[16]);
            e_st = (36'd1 << 33) | (36'(usr) << 35) | (36'(wr) << 32) | 36'(va);
            if (hw[17]) e_st = e_st | (36'd1 << 31) | (36'(hw[15]) << 29);
            if (prb) e_st = e_st | (36'(hw[16]) << 30) | (36'(hw[15]) << 29) | (36'(hw[14]) << 28);
            if (grant) begin
                e_done = 1; e_fail = 0; e_xv = 1; e_xm = hw[16];
                e_xb = 64'(hw[10:0]) * 512;
            end else begin
                e_done = prb; e_fail = !prb;
            end
        end

        for (int g = 0; g < 100 && !req_ready; g++) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_user = usr; req_write = wr;
        req_probe = prb; exec_base = PPN_W'(eb); user_base = PPN_W'(ub);
        for (int c = 0; c < 60 && !seen; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (c == 0) check("R10", "ready low while busy", 64'(req_ready), 64'd0);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = wd; pend = 0;
                end else cnt--;
            end
            if (mem_req_valid) begin
                nreq++; gaddr = mem_req_addr;
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = wd;
                end else begin
                    pend = 1; cnt = dly - 1;
                end
            end
            if (walk_done || walk_fail) begin
                seen = 1; g_done = walk_done; g_fail = walk_fail; g_xv = xpte_valid;
                g_xm = xpte_modify; g_xb = xpte_base; g_st = status_word;
            end
        end
        mem_rsp_valid = 1'b0;
        check("R10", "walk completed", 64'(seen), 64'd1);
        if (enxm) begin
            check("R9", "no read on missing memory", 64'(nreq), 64'd0);
            check("R9", "status", 64'(g_st), 64'(e_st));
        end else begin
            check("R10", "one read per walk", 64'(nreq), 64'd1);
            check(rtag, "entry word address", 64'(gaddr), 64'(ea));
            check(prb ? "R8" : "R7", "status", 64'(g_st), 64'(e_st));
        end
        check(prb ? "R8" : "R6", "done", 64'(g_done), 64'(e_done));
        check("R6", "fail", 64'(g_fail), 64'(e_fail));
        check("R6", "entry valid/modify", 64'({g_xv, g_xm}), 64'({e_xv, e_xm}));
        check("R5", "entry base", 64'(g_xb), e_xb);
        @(negedge clk);
        check("R10", "pulse is one cycle", 64'({walk_done, walk_fail}), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=hang expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [35:0] wd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "ready in reset", 64'(req_ready), 64'd1);
        check("R11", "outputs quiet", 64'({walk_done, walk_fail, mem_req_valid, xpte_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "ready after reset", 64'(req_ready), 64'd1);

        // region boundaries, executive table
        wd = 36'h6_0123_C045;
        run_walk({9'o337, 9'd5}, 0, 0, 0, 'h120, 'h0A0, wd, 1);
        run_walk({9'o340, 9'd5}, 0, 0, 0, 'h120, 'h0A0, wd, 0);
        run_walk({9'o377, 9'd5}, 0, 0, 0, 'h120, 'h0A0, wd, 2);
        run_walk({9'o400, 9'd5}, 0, 0, 0, 'h120, 'h0A0, wd, 1);
        run_walk({9'o777, 9'd5}, 0, 0, 0, 'h120, 'h0A0, wd, 3);
        // user table, odd and even halves (R5)
        run_walk({9'o341, 9'd0}, 1, 0, 0, 'h120, 'h0A0, {18'h2_0007, 18'h3_0055}, 1);
        run_walk({9'o342, 9'd0}, 1, 0, 0, 'h120, 'h0A0, {18'h2_0007, 18'h3_0055}, 1);
        // write to read-only page: R6 fail, R7 status
        run_walk({9'o12, 9'd77}, 1, 1, 0, 'h10, 'h20, {18'h2_8011, 18'h0}, 0);
        // inaccessible page probe: R8
        run_walk({9'o13, 9'd1}, 0, 1, 1, 'h10, 'h20, {18'h0, 18'h1_C022}, 2);
        // address limit: last legal word and first missing word (R9)
        run_walk({9'd255, 9'd0}, 1, 0, 0, 'h10, 'h2FF, {18'h0, 18'h2_0001}, 1);
        run_walk({9'd256, 9'd0}, 1, 0, 0, 'h10, 'h2FF, {18'h2_0001, 18'h0}, 1);
        run_walk({9'd256, 9'd0}, 1, 1, 1, 'h10, 'h2FF, {18'h2_0001, 18'h0}, 1);
        run_walk({9'o500, 9'd3}, 0, 0, 0, 'h7FF, 'h10, wd, 1);

        for (int i = 0; i < 160; i++) begin
            logic [17:0] va;
            int unsigned eb, ub;
            va = 18'($urandom);
            eb = $urandom_range(0, 'h2FF);
            ub = $urandom_range(0, 'h2FF);
            if ($urandom_range(0, 9) == 0) eb = $urandom_range('h2F0, 'h7FF);
            if ($urandom_range(0, 9) == 0) ub = $urandom_range('h2F0, 'h7FF);
            wd = {4'($urandom), 32'($urandom)};
            run_walk(va, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                     eb, ub, wd, $urandom_range(0, 4));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule